// File: doc/BRIEF.md
# Upper Memory Attribute Decoder

This block decides, for every 16 KB slot between 0x80000 and 0xFFFFF, how a processor access is routed. Each access goes to ROM chip select, to external memory, or to internal RAM, and reads and writes are routed separately. The routing comes from a small set of configuration registers written through a simple write port, plus an input from the EMS translator that flags an address landing in an active EMS page. Addresses outside the window always go to internal memory. The RAM and ROM arrays and the EMS page translation are outside this block.

The address-to-attribute path is purely combinational. A configuration write is captured on a clock edge, so new attributes appear on the cycle after the write strobe. Register indices 0 to 5 are used. Indices 6 and 7 are unused, and writes to them have no effect.

Top module: `mem_attr_decoder`

## Requirements
- R1: An address below 0x80000 or at or above 0x100000 gives rd_int=1 and wr_int=1, with rd_ext, wr_ext and rom_sel all 0, whatever the configuration or ems_hit.
- R2: In 0x80000–0x9FFFF, bit 7 of register 1 set routes reads and writes internal. When it is clear, both go external, unless ems_hit is asserted.
- R3: Register 2 holds the shadow-read bits for the A and B areas. Bits 4..7 cover slots 0xA0000, 0xA4000, 0xA8000 and 0xAC000. Bits 0..3 cover 0xB0000 through 0xBC000. A set bit routes both reads and writes of that slot internal. A clear bit routes both external.
- R4: Register 3 bits 0..7 cover slots 0xC0000..0xDC000 in ascending order. Register 4 bits 0..7 cover 0xE0000..0xFC000 in ascending order. A set bit routes reads of that slot internal; a clear bit routes them external.
- R5: Register 0 bits 0..3 are ROM-select bits, one per 64 KB block: bit 0 for F, bit 1 for E, bit 2 for D, bit 3 for C. A cleared bit gives rom_sel=1 for the block, with all four routing outputs 0.
- R6: Register 0 bits 4..7 are write-protect bits in the same F/E/D/C order. In the C–F area a write is internal only when the block's protect bit is clear and the slot's shadow-read bit is set. Otherwise it is external.
- R7: With bit 6 of register 5 set, every slot from 0xA0000 upward that is not under ROM select routes reads and writes external.
- R8: With ems_hit asserted on an in-window address, and neither ROM select nor relocation applying, reads and writes go internal.
- R9: Priority is fixed as ROM select, then relocation, then EMS hit, then the shadow bits.
- R10: Reset values are 0xFE for register 0 and 0x00 for all other registers. After reset, the F block is ROM-selected and the rest of the window is external.
- R11: A register write takes effect on the clock edge that samples cfg_we, not before. A write to index 6 or 7 changes no output.
- R12: Exactly one of rom_sel, rd_int and rd_ext is 1 at any time. Exactly one of rom_sel, wr_int and wr_ext is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| addr | input | 24 | Access address |
| ems_hit | input | 1 | Address lies in an active EMS page |
| rom_sel | output | 1 | ROM chip select |
| rd_int | output | 1 | Read goes to internal RAM |
| rd_ext | output | 1 | Read goes to external bus |
| wr_int | output | 1 | Write goes to internal RAM |
| wr_ext | output | 1 | Write goes to external bus |

## Verification
The attribute sources meet in one cycle when a single slot is claimed at once by a cleared ROM bit, by relocation, by an EMS hit and by its shadow bit. Directed cases set these sources in combination on the same F, E and A slots. Random rounds load all registers with random values and drive random ems_hit together with addresses around and inside the window. Each result is judged against a bench model that walks the priority order from the 64 KB block letter. A second overlap arises when a configuration write and an address lookup share a cycle. The bench samples the outputs just before the capturing edge and again after it, and expects the old attributes and then the new ones.

// File: rtl/mem_attr_pkg.sv
package mem_attr_pkg;
  localparam int DATA_W    = 8;
  localparam int NUM_REGS  = 6;
  localparam int SEL_W     = 3;
  localparam int REG_ROM   = 0;
  localparam int REG_LOW   = 1;
  localparam int REG_MISC  = 5;
  localparam int LOW_EN_B  = 7;
  localparam int RELOC_B   = 6;

  typedef struct packed {
    logic rom;
    logic rd_int;
    logic rd_ext;
    logic wr_int;
    logic wr_ext;
  } attr_t;

  // bit inside a shadow register for a 16 KB slot (slot 0 = 0x80000)
  function automatic logic [2:0] shadow_bit_of(input logic [4:0] slot);
    if (slot[4:3] == 2'b01) return {~slot[2], slot[1:0]};
    return slot[2:0];
  endfunction

  // shadow register index for slots 8..31
  function automatic logic [2:0] shadow_reg_of(input logic [4:0] slot);
    return {1'b0, slot[4:3]} + 3'd1;
  endfunction

  // ROM bit for slots 16..31: F block -> 0, C block -> 3
  function automatic logic [1:0] rom_bit_of(input logic [4:0] slot);
    return ~slot[3:2];
  endfunction
endpackage

// File: rtl/mem_attr_cfg.sv
module mem_attr_cfg
  import mem_attr_pkg::*;
#(
  parameter logic [DATA_W-1:0] ROM_RST = 8'hFE
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [SEL_W-1:0]                 cfg_sel,
  input  logic [DATA_W-1:0]                cfg_wdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_V = (g == REG_ROM) ? ROM_RST : '0;
    logic hit;
    assign hit = cfg_we && (cfg_sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[g] <= RST_V;
      else if (hit) regs[g] <= cfg_wdata;
    end
  end

  // R11: a write is captured at the edge that samples the strobe
  a_r11_cfg_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel < SEL_W'(NUM_REGS)) |=> regs[$past(cfg_sel)] == $past(cfg_wdata));
  // R11: unused indices leave every register unchanged
  a_r11_unused_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel >= SEL_W'(NUM_REGS)) |=> $stable(regs));
endmodule

// File: rtl/mem_attr_seg.sv
module mem_attr_seg
  import mem_attr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input  logic [ADDR_W-1:0]               addr,
  input  logic                            ems_hit,
  output attr_t                           attr,
  output logic                            in_win,
  output logic                            rom_hit,
  output logic                            remap_hit
);
  localparam int SLOT_LSB = 14;

  logic [4:0] slot;
  logic       low_area, upper_area, sh_rd, wp;
  logic [2:0] sh_reg;
  logic [1:0] rb;

  assign slot       = addr[SLOT_LSB+4:SLOT_LSB];
  assign in_win     = (addr[ADDR_W-1:20] == '0) && addr[19];
  assign low_area   = (slot[4:3] == 2'b00);
  assign upper_area = slot[4];
  assign rb         = rom_bit_of(slot);
  assign sh_reg     = shadow_reg_of(slot);

  assign rom_hit    = in_win && upper_area && !regs[REG_ROM][{1'b0, rb}];
  assign remap_hit  = in_win && !low_area && regs[REG_MISC][RELOC_B];
  assign sh_rd      = low_area ? regs[REG_LOW][LOW_EN_B] : regs[sh_reg][shadow_bit_of(slot)];
  assign wp         = upper_area && regs[REG_ROM][{1'b1, rb}];

  always_comb begin
    attr = '0;
    if (!in_win) begin
      attr.rd_int = 1'b1;
      attr.wr_int = 1'b1;
    end else if (rom_hit) begin
      attr.rom = 1'b1;
    end else if (remap_hit) begin
      attr.rd_ext = 1'b1;
      attr.wr_ext = 1'b1;
    end else if (ems_hit) begin
      attr.rd_int = 1'b1;
      attr.wr_int = 1'b1;
    end else begin
      attr.rd_int = sh_rd;
      attr.rd_ext = !sh_rd;
      attr.wr_int = sh_rd && !wp;
      attr.wr_ext = !(sh_rd && !wp);
    end
  end
endmodule

// File: rtl/mem_attr_decoder.sv
module mem_attr_decoder
  import mem_attr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [7:0]        cfg_wdata,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ems_hit,
  output logic              rom_sel,
  output logic              rd_int,
  output logic              rd_ext,
  output logic              wr_int,
  output logic              wr_ext
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  attr_t attr;
  logic  in_win, rom_hit, remap_hit;

  mem_attr_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .regs(regs)
  );

  mem_attr_seg #(.ADDR_W(ADDR_W)) u_seg (
    .regs(regs), .addr(addr), .ems_hit(ems_hit), .attr(attr),
    .in_win(in_win), .rom_hit(rom_hit), .remap_hit(remap_hit)
  );

  assign rom_sel = attr.rom;
  assign rd_int  = attr.rd_int;
  assign rd_ext  = attr.rd_ext;
  assign wr_int  = attr.wr_int;
  assign wr_ext  = attr.wr_ext;

  // R1: outside the window everything is internal
  a_r1_outside_internal: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= ADDR_W'(32'h100000) || addr < ADDR_W'(32'h80000)) |->
      (rd_int && wr_int && !rd_ext && !wr_ext && !rom_sel));
  // R12: one read route and one write route
  a_r12_read_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rom_sel, rd_int, rd_ext}) == 1);
  a_r12_write_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rom_sel, wr_int, wr_ext}) == 1);
  // R6: an internal write inside the window always has an internal read
  a_r6_write_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_int |-> rd_int);
  // R5: ROM select only in the C..F area
  a_r5_rom_area: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (addr[19:18] == 2'b11 && addr[ADDR_W-1:20] == '0));
  // R9: relocation overrides an EMS hit
  a_r9_reloc_over_ems: assert property (@(posedge clk) disable iff (!rst_n)
    (remap_hit && !rom_hit) |-> (rd_ext && wr_ext));
endmodule

// File: tb/mem_attr_decoder_test.sv
module mem_attr_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [23:0] addr = '0;
  logic        ems_hit = 1'b0;
  logic        rom_sel, rd_int, rd_ext, wr_int, wr_ext;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] mdl [6];

  always #5 clk = ~clk;

  mem_attr_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .addr(addr), .ems_hit(ems_hit),
    .rom_sel(rom_sel), .rd_int(rd_int), .rd_ext(rd_ext),
    .wr_int(wr_int), .wr_ext(wr_ext)
  );

  // expected {rom, rd_int, rd_ext, wr_int, wr_ext}
  function automatic logic [4:0] model(input logic [23:0] a, input logic e);
    logic [3:0] blk;
    logic [1:0] q;
    logic sh, wp;
    int ri;
    if (a < 24'h080000 || a >= 24'h100000) return 5'b01010;
    blk = a[19:16];
    q   = a[15:14];
    ri  = 15 - int'(blk);
    if (blk >= 4'hC && !mdl[0][ri]) return 5'b10000;
    if (blk >= 4'hA && mdl[5][6]) return 5'b00101;
    if (e) return 5'b01010;
    wp = 1'b0;
    case (blk)
      4'h8, 4'h9: sh = mdl[1][7];
      4'hA: sh = mdl[2][4 + int'(q)];
      4'hB: sh = mdl[2][int'(q)];
      4'hC: sh = mdl[3][int'(q)];
      4'hD: sh = mdl[3][4 + int'(q)];
      4'hE: sh = mdl[4][int'(q)];
      default: sh = mdl[4][4 + int'(q)];
    endcase
    if (blk >= 4'hC) wp = mdl[0][4 + ri];
    return {1'b0, sh, !sh, sh && !wp, !(sh && !wp)};
  endfunction

  task automatic check(input logic [4:0] exp, input string tag);
    logic [4:0] got;
    got = {rom_sel, rd_int, rd_ext, wr_int, wr_ext};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h ems=%0b got=%b expected=%b", tag, addr, ems_hit, got, exp);
    end
  endtask

  task automatic look(input logic [23:0] a, input logic e, input string tag);
    @(negedge clk);
    addr = a;
    ems_hit = e;
    #1;
    check(model(a, e), tag);
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sel = 3'(idx);
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < 6) mdl[idx] = d;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    mdl[0] = 8'hFE;
    for (int i = 1; i < 6; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    look(24'h0F0000, 1'b0, "R10 F0 rom");
    check(5'b10000, "R10 F0 literal");
    look(24'h0C4000, 1'b0, "R10 C4 ext");
    look(24'h080000, 1'b0, "R10 low ext");
    // R1 outside
    look(24'h07FFFF, 1'b0, "R1 below");
    look(24'h100000, 1'b1, "R1 above");
    look(24'h3F0000, 1'b0, "R1 high");

    // R2 low area
    wr(1, 8'h80);
    look(24'h09C000, 1'b0, "R2 low int");
    wr(1, 8'h7F);
    look(24'h084000, 1'b0, "R2 low ext");
    look(24'h084000, 1'b1, "R8 low ems");

    // R3 nibble swap: enable only A4 slot (bit 5) and B8 slot (bit 2)
    wr(2, 8'h24);
    look(24'h0A4000, 1'b0, "R3 A4 int");
    look(24'h0A0000, 1'b0, "R3 A0 ext");
    look(24'h0B8000, 1'b0, "R3 B8 int");
    look(24'h0B4000, 1'b0, "R3 B4 ext");

    // R4/R5/R6: ROM off everywhere, protect E only
    wr(0, 8'h2F);
    wr(3, 8'h81);
    wr(4, 8'h81);
    look(24'h0C0000, 1'b0, "R4 C0 int");
    look(24'h0DC000, 1'b0, "R4 DC int");
    look(24'h0C4000, 1'b0, "R4 C4 ext");
    look(24'h0E0000, 1'b0, "R6 E0 protected");
    look(24'h0FC000, 1'b0, "R6 FC writable");
    wr(0, 8'hFB);
    look(24'h0D8000, 1'b0, "R5 D rom");
    look(24'h0E0000, 1'b0, "R5 E not rom");

    // R7/R8/R9 priority
    look(24'h0E4000, 1'b1, "R8 ems int");
    wr(5, 8'h40);
    look(24'h0E4000, 1'b1, "R9 reloc over ems");
    look(24'h0A4000, 1'b0, "R7 A4 reloc");
    look(24'h0D0000, 1'b1, "R9 rom over reloc");
    look(24'h098000, 1'b0, "R7 low untouched");

    // R11 timing: old value before the edge, new after
    @(negedge clk);
    addr = 24'h0A4000; ems_hit = 1'b0;
    cfg_we = 1'b1; cfg_sel = 3'd5; cfg_wdata = 8'h00;
    #1 check(5'b00101, "R11 before edge");
    @(posedge clk);
    #1 check(5'b01010, "R11 after edge");
    @(negedge clk);
    cfg_we = 1'b0;
    mdl[5] = 8'h00;
    wr(6, 8'hFF);
    wr(7, 8'h00);
    look(24'h0A4000, 1'b0, "R11 unused idx");
    look(24'h0D0000, 1'b0, "R11 unused idx rom");
    look(24'h0A0000, 1'b0, "R11 unused idx A0");

    // random rounds
    for (int r = 0; r < 60; r++) begin
      for (int k = 0; k < 6; k++) wr(k, 8'($urandom));
      for (int n = 0; n < 24; n++) begin
        logic [23:0] a;
        a = 24'h070000 + 24'($urandom_range(0, 24'h0A0000));
        look(a, 1'($urandom), "R9 random");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule